// File: doc/BRIEF.md
# SPI Slave Byte Transceiver

This block is the slave side of an SPI link, built around a system clock that runs well above the serial clock. The serial clock, the active-low select and the master-out data line are brought into the system clock domain through synchronizer chains. Edges of the serial clock are then found by comparing successive synchronized samples. A parallel transmit byte is shifted out on the slave-out line, most significant bit first. At the same time the bits arriving from the master are assembled into a received byte, which is presented with a valid pulse one system clock wide.

Clock polarity and clock phase are static configuration inputs, so all four SPI modes are covered. With phase 0 the slave loads its transmit byte when select falls and presents the first bit before any clock edge. Every byte then needs its own select pulse. With phase 1 the first clock edge of each byte loads the transmit byte, and any number of bytes may follow one another while select stays low. The slave-out line comes with an output enable that is low whenever the slave is not selected, so that a pad or a shared line can be released.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_byte` is 0 and `miso_oe` is 0 while `ss_n_in` is high.
- R2: Bytes are 8 bits and travel most significant bit first. `rx_byte` equals the 8 MOSI values sampled, the first one in bit 7.
- R3: With `cfg_cpha`=0, bit 7 of `tx_byte` is on `miso_out` within 4 system clocks after `ss_n_in` falls, before the first SCK edge. MOSI is sampled on the leading SCK edge and MISO moves to the next bit on the trailing edge.
- R4: With `cfg_cpha`=0, once 8 bits are received no further byte is produced until `ss_n_in` has gone high and low again. Extra SCK cycles under the same low select produce no `rx_valid`.
- R5: With `cfg_cpha`=1, the first leading SCK edge of a byte loads `tx_byte` and puts its bit 7 on MISO. Later leading edges shift MISO, and MOSI is sampled on trailing edges.
- R6: With `cfg_cpha`=1, consecutive bytes may be sent under one continuous low select. Each byte delivers its own `rx_valid`, and each byte reloads `tx_byte`.
- R7: SCK idles low for `cfg_cpol`=0, where the leading edge is rising. It idles high for `cfg_cpol`=1, where the leading edge is falling. All four combinations of `cfg_cpol` and `cfg_cpha` transfer data correctly.
- R8: If `ss_n_in` rises before 8 bits are sampled, the partial byte is dropped without `rx_valid`, and the next byte is received in full.
- R9: `miso_oe` is 1 exactly while the synchronized select is low. The bit counter is held at zero while select is high.
- R10: `rx_valid` is high for exactly one system clock per completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level (0 low, 1 high) |
| cfg_cpha | input | 1 | 0: sample leading edge; 1: sample trailing edge |
| sck_in | input | 1 | Serial clock from master (asynchronous) |
| ss_n_in | input | 1 | Active-low slave select (asynchronous) |
| mosi_in | input | 1 | Serial data from master |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for `miso_out` |
| tx_byte | input | DATA_W | Byte to send, loaded at start of each byte |
| rx_byte | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-clock strobe: `rx_byte` updated |

## Verification
The bench runs every SPI mode with directed patterns (all zeros, all ones, alternating) and seeded random bytes. In each byte it checks both the MOSI-to-`rx_byte` path and the `tx_byte`-to-MISO path. Phase 0 runs include surplus SCK cycles under a select that is still low. A design that kept counting would raise a spurious `rx_valid` there. Phase 1 runs stream bytes back to back under one select with a fresh `tx_byte` for each. A design that failed to reload would repeat stale data, and one that mishandled the byte boundary would shift everything by a bit. An aborted byte, with select raised after five bits, is followed by a full byte. A counter that was not cleared would fire early and misalign that full byte.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   // index of each line inside the synchronizer bundle
   localparam int unsigned LN_SCK  = 0;
   localparam int unsigned LN_SS   = 1;
   localparam int unsigned LN_MOSI = 2;
   localparam int unsigned LN_NUM  = 3;

   typedef struct packed {
      logic sample;   // capture MOSI
      logic shift;    // advance MISO
   } spi_strobe_t;

   function automatic int unsigned cnt_width(input int unsigned bits);
      return (bits <= 2) ? 1 : $clog2(bits);
   endfunction
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned CHAIN_W = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_slv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
   import spi_slv_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpol,
   input  logic        cpha,
   input  logic        sck_s,
   output spi_strobe_t stb
);
   logic sck_d;
   logic rise, fall, lead, trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise  = sck_s & ~sck_d;
   assign fall  = ~sck_s & sck_d;
   assign lead  = cpol ? fall : rise;
   assign trail = cpol ? rise : fall;

   always_comb begin
      stb.sample = cpha ? trail : lead;
      stb.shift  = cpha ? lead  : trail;
   end
endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  logic              sel,
   input  logic              sel_start,
   input  spi_strobe_t       stb,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              tx_msb,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic [cnt_width(DATA_W)-1:0] bit_cnt
);
   localparam int unsigned CW = cnt_width(DATA_W);
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic              in_byte;
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] rx_next;

   assign rx_next = {rx_sr[DATA_W-2:0], mosi_s};
   assign tx_msb  = tx_sr[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_byte  <= 1'b0;
         bit_cnt  <= '0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (!sel) begin
            in_byte <= 1'b0;
            bit_cnt <= '0;
         end else if (!cpha && sel_start) begin
            tx_sr   <= tx_byte;
            in_byte <= 1'b1;
            bit_cnt <= '0;
         end else begin
            if (stb.shift) begin
               if (cpha && !in_byte) begin
                  tx_sr   <= tx_byte;
                  in_byte <= 1'b1;
               end else if (in_byte) begin
                  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
               end
            end
            if (stb.sample && in_byte) begin
               rx_sr <= rx_next;
               if (bit_cnt == LAST) begin
                  rx_byte  <= rx_next;
                  rx_valid <= 1'b1;
                  bit_cnt  <= '0;
                  in_byte  <= 1'b0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              sck_in,
   input  logic              ss_n_in,
   input  logic              mosi_in,
   output logic              miso_out,
   output logic              miso_oe,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid
);
   localparam int unsigned CW = cnt_width(DATA_W);
   localparam logic [LN_NUM-1:0] SYNC_RST = LN_NUM'(1) << LN_SS;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_byte_slave: DATA_W must be at least 2");
      end
   endgenerate

   logic [LN_NUM-1:0] raw_in, sync_out;
   logic              sck_s, ss_s, mosi_s, ss_d, sel_start;
   spi_strobe_t       stb;
   logic [CW-1:0]     bit_cnt;

   assign raw_in[LN_SCK]  = sck_in;
   assign raw_in[LN_SS]   = ss_n_in;
   assign raw_in[LN_MOSI] = mosi_in;

   spi_slv_sync #(.WIDTH(LN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   assign sck_s  = sync_out[LN_SCK];
   assign ss_s   = sync_out[LN_SS];
   assign mosi_s = sync_out[LN_MOSI];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ss_d <= 1'b1;
      else        ss_d <= ss_s;
   end
   assign sel_start = ss_d & ~ss_s;

   spi_slv_edge u_edge (
      .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
      .sck_s(sck_s), .stb(stb)
   );

   spi_slv_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha), .sel(~ss_s),
      .sel_start(sel_start), .stb(stb), .mosi_s(mosi_s),
      .tx_byte(tx_byte), .tx_msb(miso_out), .rx_byte(rx_byte),
      .rx_valid(rx_valid), .bit_cnt(bit_cnt)
   );

   assign miso_oe = ~ss_s;
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
   parameter int unsigned CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ss_s,
   input logic          sample_stb,
   input logic [CW-1:0] bit_cnt,
   input logic          rx_valid
);
   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> (bit_cnt == '0));

   p_valid_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !$past(ss_s));

   p_valid_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(sample_stb));
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .sample_stb(stb.sample),
   .bit_cnt(bit_cnt), .rx_valid(rx_valid)
);

// File: tb/spi_byte_slave_test.sv
`timescale 1ns/1ps
module spi_byte_slave_test;
   localparam int HP = 6;   // SCK half period in system clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpol = 1'b0, cpha = 1'b0;
   logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic [7:0] tx = 8'h00;
   logic miso, oe, rx_valid;
   logic [7:0] rx_byte;

   int checks = 0, fails = 0;
   int rx_cnt = 0, pulse_err = 0;
   logic [7:0] rx_last = 8'h00;
   logic prev_v = 1'b0;

   always #2.5 clk = ~clk;

   spi_byte_slave uut (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
      .sck_in(sck), .ss_n_in(ss_n), .mosi_in(mosi), .miso_out(miso),
      .miso_oe(oe), .tx_byte(tx), .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt  <= rx_cnt + 1;
         rx_last <= rx_byte;
         if (prev_v) pulse_err <= pulse_err + 1;
      end
      prev_v <= rx_valid;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected MSB-first reassembly of a bit stream
   function automatic logic [7:0] pack_msb(input logic [7:0] bits_in_order);
      logic [7:0] r = 8'h00;
      for (int i = 0; i < 8; i++) r = {r[6:0], bits_in_order[7-i]};
      return r;
   endfunction

   task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
      mi = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         if (!cpha) begin
            mosi = mo[i]; wclk(HP);
            mi[i] = miso; sck = ~sck; wclk(HP);
            sck = ~sck;
         end else begin
            sck = ~sck; mosi = mo[i]; wclk(HP);
            mi[i] = miso; sck = ~sck; wclk(HP);
         end
      end
   endtask

   task automatic set_mode(input int m);
      ss_n = 1'b1; wclk(4);
      cpol = m[1]; cpha = m[0]; sck = m[1]; wclk(6);
   endtask

   task automatic byte_cpha0(input logic [7:0] mo, input logic [7:0] t, input string req);
      logic [7:0] mi;
      int base;
      tx = t; base = rx_cnt;
      ss_n = 1'b0; wclk(4);
      chk(oe === 1'b1, "R9", oe, 1);
      chk(miso === t[7], "R3", miso, t[7]);
      wclk(2);
      xfer(mo, 8, mi); wclk(6);
      chk(rx_cnt == base + 1, req, rx_cnt - base, 1);
      chk(rx_last === pack_msb(mo), "R2", rx_last, pack_msb(mo));
      chk(mi === t, req, mi, t);
      ss_n = 1'b1; wclk(6);
      chk(oe === 1'b0, "R9", oe, 0);
   endtask

   logic [7:0] data_q [4];
   logic [7:0] tx_q   [4];

   initial begin : watchdog
      #(5ns * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] mi;
      int base;
      void'($urandom(32'd1234));
      wclk(5);
      chk(rx_valid === 1'b0, "R1", rx_valid, 0);
      chk(rx_byte === 8'h00, "R1", rx_byte, 0);
      chk(oe === 1'b0, "R1", oe, 0);
      rst_n = 1'b1; wclk(5);
      chk(oe === 1'b0, "R1", oe, 0);

      for (int m = 0; m < 4; m++) begin
         set_mode(m);
         if (m[0] == 1'b0) begin
            byte_cpha0(8'h00, 8'hFF, "R7");
            byte_cpha0(8'hFF, 8'h00, "R7");
            byte_cpha0(8'hA5, 8'h5A, "R3");
            for (int k = 0; k < 4; k++)
               byte_cpha0(8'($urandom), 8'($urandom), "R2");
            // R4: surplus clocks under the same select give no byte
            tx = 8'h3C; base = rx_cnt;
            ss_n = 1'b0; wclk(6);
            xfer(8'hC3, 8, mi); wclk(4);
            xfer(8'h81, 8, mi); wclk(6);
            chk(rx_cnt == base + 1, "R4", rx_cnt - base, 1);
            chk(rx_last === 8'hC3, "R4", rx_last, 8'hC3);
            ss_n = 1'b1; wclk(6);
            byte_cpha0(8'h96, 8'h69, "R4");
         end else begin
            // R6: back-to-back bytes under one select
            for (int k = 0; k < 4; k++) begin
               data_q[k] = (k == 0) ? 8'h01 : 8'($urandom);
               tx_q[k]   = (k == 3) ? 8'h80 : 8'($urandom);
            end
            ss_n = 1'b0; wclk(6);
            chk(oe === 1'b1, "R9", oe, 1);
            for (int k = 0; k < 4; k++) begin
               base = rx_cnt; tx = tx_q[k];
               xfer(data_q[k], 8, mi);
               chk(rx_cnt == base + 1, "R6", rx_cnt - base, 1);
               chk(rx_last === pack_msb(data_q[k]), "R6", rx_last, data_q[k]);
               chk(mi === tx_q[k], "R5", mi, tx_q[k]);
            end
            ss_n = 1'b1; wclk(6);
            chk(oe === 1'b0, "R9", oe, 0);
         end
         // R8: abort mid-byte, then a full byte
         base = rx_cnt; tx = 8'hE7;
         ss_n = 1'b0; wclk(6);
         xfer(8'hF0, 5, mi);
         sck = cpol; wclk(HP);
         ss_n = 1'b1; wclk(8);
         chk(rx_cnt == base, "R8", rx_cnt - base, 0);
         tx = 8'h42; ss_n = 1'b0; wclk(6);
         xfer(8'h5B, 8, mi); wclk(6);
         chk(rx_cnt == base + 1, "R8", rx_cnt - base, 1);
         chk(rx_last === 8'h5B, "R8", rx_last, 8'h5B);
         chk(mi === 8'h42, "R7", mi, 8'h42);
         ss_n = 1'b1; wclk(6);
      end

      chk(pulse_err == 0, "R10", pulse_err, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule